// File: doc/BRIEF.md
# Multi-Channel Hex Result Reporter

This block takes one signed result word from each of a set of measurement channels, captures the whole set when a shared strobe marks it valid, and sends it as one line of ASCII text over an asynchronous serial line. Each word is written as fixed-width uppercase hexadecimal, with a comma between channels. The line is closed by a carriage return and a line feed, so a host terminal or script can split results on line boundaries.

Inside the block, a frame sequencer walks the captured words nibble by nibble and offers one character at a time, through a valid/ready handshake, to a built-in UART transmitter. A programmable divider sets the bit period. The bit rate is chosen so that a full frame finishes before the next result set is due. If a strobe arrives while a frame is still going out, that strobe is refused and a sticky overrun indication is raised.

Top module: `hex_result_reporter`

## Requirements
- R1: After reset, `tx_o` is high, `busy_o` is low and `overrun_o` is low.
- R2: One accepted strobe produces exactly NUM_CH*(RES_W/4) hex characters, NUM_CH-1 commas (0x2C), one carriage return (0x0D) and one line feed (0x0A). That is 211 bytes with the default parameters, and the CR/LF pair comes last.
- R3: Channels are sent in order from channel 0 upward, where channel k is `results_i[k*RES_W +: RES_W]`. Each channel's characters are sent most significant nibble first. Nibble values 0..9 are sent as 0x30..0x39, and values 10..15 as 0x41..0x46.
- R4: Each byte is sent as a low start bit, then 8 data bits with the LSB first, then a high stop bit. Every bit lasts `baud_div_i`+1 clock cycles. `tx_o` is high whenever `busy_o` is low.
- R5: All channel words are captured on the clock edge that accepts the strobe. Later changes on `results_i` do not alter the frame being sent.
- R6: A strobe that arrives while `busy_o` is high sets `overrun_o`, starts no second frame and does not change the frame in progress. With no strobe, `overrun_o` holds its value.
- R7: A strobe that arrives while `busy_o` is low is accepted, and it clears `overrun_o` on the next cycle.
- R8: `busy_o` is high from the cycle after an accepted strobe until the stop bit of the final line feed has ended. A strobe in the first cycle that `busy_o` is low is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| results_i | input | NUM_CH*RES_W | Packed channel result words, channel 0 in the low bits |
| res_valid_i | input | 1 | Single-cycle strobe marking a new result set |
| baud_div_i | input | DIV_W | Bit period minus one, in clock cycles |
| tx_o | output | 1 | Serial data out, idle high |
| busy_o | output | 1 | A frame is being sent |
| overrun_o | output | 1 | Sticky flag: a strobe was refused during a frame |

## Verification
Accepting a frame and flagging an overrun both depend on the same strobe. The only thing that decides between them is the value of `busy_o` in the strobe's cycle, so the edge where one frame ends and the next begins is the critical point. The bench provokes this in two ways. It pulses the strobe in the middle of a frame with different data on `results_i`, and expects the overrun flag, an unchanged frame and no follow-on frame. It also pulses the strobe in the very first cycle that `busy_o` reads low, and expects a clean accept with new data and the flag clear. In both cases the decoded serial bytes are compared with a frame the bench builds itself.

// File: rtl/hex_rpt_pkg.sv
package hex_rpt_pkg;
  typedef enum logic [2:0] {SQ_IDLE, SQ_HEX, SQ_SEP, SQ_CR, SQ_LF} sq_state_e;

  localparam logic [7:0] CHR_SEP = 8'h2C;
  localparam logic [7:0] CHR_CR  = 8'h0D;
  localparam logic [7:0] CHR_LF  = 8'h0A;

  function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction
endpackage

// File: rtl/hex_frame_seq.sv
module hex_frame_seq
  import hex_rpt_pkg::*;
#(
  parameter int NUM_CH = 30,
  parameter int RES_W  = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [NUM_CH*RES_W-1:0] results_i,
  output logic [7:0]              byte_o,
  output logic                    byte_vld_o,
  input  logic                    byte_rdy_i,
  output logic                    active_o
);
  localparam int NIB  = RES_W / 4;
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int NB_W = (NIB > 1) ? $clog2(NIB) : 1;

  sq_state_e                 state_q;
  logic [NUM_CH*RES_W-1:0]   shadow_q;
  logic [CH_W-1:0]           ch_q;
  logic [NB_W-1:0]           nib_q;
  logic [RES_W-1:0]          words [NUM_CH];
  logic [RES_W-1:0]          cur_word;
  logic [3:0]                nibs [NIB];
  logic [3:0]                cur_nib;
  logic                      fire;
  logic                      last_nib, last_ch;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_word
    assign words[g] = shadow_q[g*RES_W +: RES_W];
  end

  for (genvar k = 0; k < NIB; k++) begin : g_nib
    assign nibs[k] = cur_word[(NIB-1-k)*4 +: 4];
  end

  assign cur_word = words[ch_q];
  assign cur_nib  = nibs[nib_q];
  assign fire     = byte_vld_o & byte_rdy_i;
  assign last_nib = (nib_q == NB_W'(NIB-1));
  assign last_ch  = (ch_q == CH_W'(NUM_CH-1));

  always_comb begin
    unique case (state_q)
      SQ_HEX:  byte_o = nib_to_ascii(cur_nib);
      SQ_SEP:  byte_o = CHR_SEP;
      SQ_CR:   byte_o = CHR_CR;
      SQ_LF:   byte_o = CHR_LF;
      default: byte_o = 8'h00;
    endcase
  end

  assign byte_vld_o = (state_q != SQ_IDLE);
  assign active_o   = (state_q != SQ_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= '0;
    else if (start_i && state_q == SQ_IDLE) shadow_q <= results_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      ch_q    <= '0;
      nib_q   <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (start_i) begin
          state_q <= SQ_HEX;
          ch_q    <= '0;
          nib_q   <= '0;
        end
        SQ_HEX: if (fire) begin
          if (last_nib) begin
            nib_q   <= '0;
            state_q <= last_ch ? SQ_CR : SQ_SEP;
          end else begin
            nib_q <= nib_q + 1'b1;
          end
        end
        SQ_SEP: if (fire) begin
          ch_q    <= ch_q + 1'b1;
          state_q <= SQ_HEX;
        end
        SQ_CR: if (fire) state_q <= SQ_LF;
        SQ_LF: if (fire) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hex_uart_tx.sv
module hex_uart_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic [7:0]       data_i,
  input  logic             vld_i,
  output logic             rdy_o,
  output logic             tx_o,
  output logic             active_o
);
  localparam int FRAME_BITS = 10;
  localparam int BC_W       = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh_q;
  logic [BC_W-1:0]       bits_q;
  logic [DIV_W-1:0]      cnt_q;
  logic                  act_q;

  assign rdy_o    = ~act_q;
  assign active_o = act_q;
  assign tx_o     = act_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      bits_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else if (!act_q) begin
      if (vld_i) begin
        sh_q   <= {1'b1, data_i, 1'b0};
        bits_q <= BC_W'(FRAME_BITS-1);
        cnt_q  <= div_i;
        act_q  <= 1'b1;
      end
    end else if (cnt_q == '0) begin
      if (bits_q == '0) begin
        act_q <= 1'b0;
      end else begin
        sh_q   <= {1'b1, sh_q[FRAME_BITS-1:1]};
        bits_q <= bits_q - 1'b1;
        cnt_q  <= div_i;
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/hex_result_reporter.sv
module hex_result_reporter #(
  parameter int NUM_CH = 30,
  parameter int RES_W  = 24,
  parameter int DIV_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH*RES_W-1:0] results_i,
  input  logic                    res_valid_i,
  input  logic [DIV_W-1:0]        baud_div_i,
  output logic                    tx_o,
  output logic                    busy_o,
  output logic                    overrun_o
);
  logic       seq_act, tx_act, start;
  logic [7:0] byte_val;
  logic       byte_vld, byte_rdy;
  logic       ovr_q;

  assign busy_o    = seq_act | tx_act;
  assign start     = res_valid_i & ~busy_o;
  assign overrun_o = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ovr_q <= 1'b0;
    else if (res_valid_i) ovr_q <= busy_o;
  end

  hex_frame_seq #(.NUM_CH(NUM_CH), .RES_W(RES_W)) seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .results_i  (results_i),
    .byte_o     (byte_val),
    .byte_vld_o (byte_vld),
    .byte_rdy_i (byte_rdy),
    .active_o   (seq_act)
  );

  hex_uart_tx #(.DIV_W(DIV_W)) tx_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_i    (baud_div_i),
    .data_i   (byte_val),
    .vld_i    (byte_vld),
    .rdy_o    (byte_rdy),
    .tx_o     (tx_o),
    .active_o (tx_act)
  );
endmodule

// File: rtl/hex_rpt_chk.sv
module hex_rpt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       res_valid_i,
  input logic       tx_o,
  input logic       busy_o,
  input logic       overrun_o,
  input logic       byte_vld,
  input logic       byte_rdy,
  input logic [7:0] byte_val
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o); // R4
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !busy_o) |=> busy_o); // R8
  AST_OVERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && busy_o) |=> overrun_o); // R6
  AST_OVERRUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> $stable(overrun_o)); // R6
  AST_OVERRUN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !busy_o) |=> !overrun_o); // R7
  AST_BYTE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld && !byte_rdy) |=> (byte_vld && $stable(byte_val))); // R3
endmodule

bind hex_result_reporter hex_rpt_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .res_valid_i (res_valid_i),
  .tx_o        (tx_o),
  .busy_o      (busy_o),
  .overrun_o   (overrun_o),
  .byte_vld    (byte_vld),
  .byte_rdy    (byte_rdy),
  .byte_val    (byte_val)
);

// File: tb/hex_result_reporter_tb_top.sv
module hex_result_reporter_tb_top;
  localparam int NUM_CH = 30;
  localparam int RES_W  = 24;
  localparam int DIV_W  = 16;
  localparam int NIB    = RES_W / 4;
  localparam int FRAME_LEN = NUM_CH*NIB + NUM_CH - 1 + 2;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [RES_W-1:0] seed;
    logic [RES_W-1:0] step;
    logic             meas;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{div: 16'd3, seed: 24'h000000, step: 24'h000000, meas: 1'b1},
    '{div: 16'd3, seed: 24'hABCDEF, step: 24'h111111, meas: 1'b0},
    '{div: 16'd1, seed: 24'hFFFFF0, step: 24'h000001, meas: 1'b0},
    '{div: 16'd2, seed: 24'h800000, step: 24'h0F1E2D, meas: 1'b0}
  };

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic [NUM_CH*RES_W-1:0] results_i = '0;
  logic                    res_valid_i = 1'b0;
  logic [DIV_W-1:0]        baud_div_i = 16'd3;
  logic                    tx_o, busy_o, overrun_o;

  int n_chk = 0, n_fail = 0;
  int bit_p = 4;
  bit rx_en = 1'b0;
  logic [7:0] rx_buf [256];
  int rx_cnt = 0;
  int frm_err = 0;
  logic [7:0] exp_buf [256];
  string hexchars = "0123456789ABCDEF";

  always #5 clk_i = ~clk_i;

  hex_result_reporter #(.NUM_CH(NUM_CH), .RES_W(RES_W), .DIV_W(DIV_W)) dut_i (
    .clk_i, .rst_ni, .results_i, .res_valid_i, .baud_div_i,
    .tx_o, .busy_o, .overrun_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // serial line decoder
  initial forever begin
    @(negedge clk_i);
    if (rx_en && tx_o == 1'b0) begin
      logic [7:0] b;
      repeat (bit_p/2) @(negedge clk_i);
      if (tx_o !== 1'b0) frm_err++;
      for (int k = 0; k < 8; k++) begin
        repeat (bit_p) @(negedge clk_i);
        b[k] = tx_o;
      end
      repeat (bit_p) @(negedge clk_i);
      if (tx_o !== 1'b1) frm_err++;
      if (rx_cnt < 256) rx_buf[rx_cnt] = b;
      rx_cnt++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  function automatic logic [RES_W-1:0] ch_val(input logic [RES_W-1:0] seed,
                                              input logic [RES_W-1:0] step, input int c);
    return seed + RES_W'(c) * step;
  endfunction

  task automatic load_results(input logic [RES_W-1:0] seed, input logic [RES_W-1:0] step);
    for (int c = 0; c < NUM_CH; c++) results_i[c*RES_W +: RES_W] = ch_val(seed, step, c);
  endtask

  task automatic build_exp(input logic [RES_W-1:0] seed, input logic [RES_W-1:0] step);
    int p = 0;
    for (int c = 0; c < NUM_CH; c++) begin
      logic [RES_W-1:0] w = ch_val(seed, step, c);
      for (int k = NIB-1; k >= 0; k--) begin
        exp_buf[p] = hexchars[int'(w[k*4 +: 4])];
        p++;
      end
      if (c != NUM_CH-1) begin exp_buf[p] = 8'h2C; p++; end
    end
    exp_buf[p] = 8'h0D; exp_buf[p+1] = 8'h0A;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy_o && guard < 20000) begin @(negedge clk_i); guard++; end
  endtask

  task automatic check_frame(input string tag);
    int bad = -1;
    chk(rx_cnt == FRAME_LEN, "R2", {tag, " byte count"}, rx_cnt, FRAME_LEN);
    for (int i = 0; i < FRAME_LEN && i < rx_cnt; i++)
      if (bad < 0 && rx_buf[i] !== exp_buf[i]) bad = i;
    if (bad < 0) chk(1'b1, "R3", {tag, " content"}, 0, 0);
    else chk(1'b0, "R3", $sformatf("%s content at byte %0d", tag, bad),
             rx_buf[bad], exp_buf[bad]);
    chk(frm_err == 0, "R4", {tag, " start/stop bits"}, frm_err, 0);
  endtask

  task automatic strobe();
    res_valid_i = 1'b1;
    @(negedge clk_i);
    res_valid_i = 1'b0;
  endtask

  initial begin
    rx_en = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(tx_o == 1'b1, "R1", "tx idle in reset", tx_o, 1);
    chk(busy_o == 1'b0, "R1", "busy in reset", busy_o, 0);
    chk(overrun_o == 1'b0, "R1", "overrun in reset", overrun_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(tx_o == 1'b1 && !busy_o, "R1", "idle after reset", {tx_o, busy_o}, 2'b10);

    foreach (VECS[v]) begin
      baud_div_i = VECS[v].div;
      bit_p = int'(VECS[v].div) + 1;
      load_results(VECS[v].seed, VECS[v].step);
      build_exp(VECS[v].seed, VECS[v].step);
      rx_cnt = 0; frm_err = 0;
      strobe();
      chk(busy_o == 1'b1, "R8", $sformatf("vec%0d busy after accept", v), busy_o, 1);
      if (VECS[v].meas) begin
        int low = 0, g = 0;
        while (tx_o && g < 100) begin @(negedge clk_i); g++; end
        while (!tx_o && low < 1000) begin @(negedge clk_i); low++; end
        // first char '0' = 0x30: start + four zero data bits
        chk(low == 5*bit_p, "R4", "bit period from low run", low, 5*bit_p);
      end
      wait_idle();
      repeat (2*bit_p + 4) @(negedge clk_i);
      check_frame($sformatf("vec%0d", v));
      chk(overrun_o == 1'b0, "R7", $sformatf("vec%0d no overrun", v), overrun_o, 0);
    end

    // R5/R6: strobe with new data in mid-frame
    baud_div_i = 16'd3; bit_p = 4;
    load_results(24'h123456, 24'h010203);
    build_exp(24'h123456, 24'h010203);
    rx_cnt = 0; frm_err = 0;
    strobe();
    repeat (300) @(negedge clk_i);
    load_results(24'hDEAD00, 24'h000777);
    strobe();
    chk(overrun_o == 1'b1, "R6", "overrun set mid-frame", overrun_o, 1);
    repeat (200) @(negedge clk_i);
    load_results(24'h000000, 24'hFFFFFF);
    wait_idle();
    repeat (12) @(negedge clk_i);
    check_frame("R5 frame kept");
    repeat (2000) @(negedge clk_i);
    chk(rx_cnt == FRAME_LEN && !busy_o, "R6", "no second frame", rx_cnt, FRAME_LEN);
    chk(overrun_o == 1'b1, "R6", "overrun sticky", overrun_o, 1);

    // R7: accepted strobe clears overrun
    load_results(24'h0A0B0C, 24'h100000);
    build_exp(24'h0A0B0C, 24'h100000);
    rx_cnt = 0; frm_err = 0;
    strobe();
    chk(overrun_o == 1'b0, "R7", "overrun cleared on accept", overrun_o, 0);
    chk(busy_o == 1'b1, "R8", "busy after second accept", busy_o, 1);

    // R8: strobe in the first cycle busy reads low
    wait_idle();
    repeat (12) @(negedge clk_i);
    check_frame("R7 frame");
    load_results(24'h5A5A5A, 24'h000010);
    strobe();
    repeat (100) @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    load_results(24'h777000, 24'h000321);
    build_exp(24'h777000, 24'h000321);
    rx_cnt = 0; frm_err = 0;
    strobe();
    chk(busy_o == 1'b1, "R8", "accept at busy fall", busy_o, 1);
    chk(overrun_o == 1'b0, "R8", "no overrun at busy fall", overrun_o, 0);
    wait_idle();
    repeat (12) @(negedge clk_i);
    check_frame("R8 frame");

    finish_run();
  end
endmodule